// File: doc/BRIEF.md
# UART Status and Error-Capture Register

This block gathers the live conditions of a UART datapath into one 32-bit status word that software reads over a simple register bus. Its inputs are FIFO occupancy, shifter and byte-count state, break detection, the clear-to-send line and per-cycle error pulses. Most flags are live and registered once. Their meaning can depend on whether the UART moves data through its FIFOs or through DMA.

Two flags are sticky and cleared by writing one: a CTS-change flag and an error flag. While the error flag is set, the error-code field keeps the code of the first error that was captured. The CTS line is asynchronous, so it passes through a two-flop synchronizer before it is inverted and before its edges are detected.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x0F000030. Bits 31:28 and 23:10 always read zero.
- R2: Bit 0 reads `rx_len_done` one cycle later, but only while `dma_mode` was 1 in that earlier cycle. Otherwise it reads 0.
- R3: Bit 1 reads `rx_not_empty` one cycle later, but only while `dma_mode` was 0 in that earlier cycle. Bit 2 reads `rx_half_full` one cycle later.
- R4: One cycle after its inputs, bit 3 is `tx_shift_idle` AND `tx_fifo_empty` when `dma_mode` is 0. It is `tx_shift_idle` AND `tx_bytes_zero` when `dma_mode` is 1.
- R5: Bit 4 reads `tx_not_full` and bit 5 reads `tx_half_empty`, each one cycle later.
- R6: Bit 6 is the inverse of `cts_pin`, two cycles after the pin is sampled.
- R7: Bit 7 sets one cycle after a level change of the synchronized CTS, which is three cycles after the pin changes. A write with bit 7 set clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: Bit 8 reads `brk_det` one cycle later.
- R9: Bit 9 sets one cycle after any error pulse and stays set until a write with bit 9 set. While it is set, bits 27:24 do not change.
- R10: The error pulses map to these codes in bits 27:24: `err_pulse[0]` missing stop → 0, `[1]` RX parity → 1, `[2]` TX overflow → 12, `[3]` RX underflow → 13, `[4]` RX overflow → 14. If several pulses arrive together, the lowest code is recorded.
- R11: A clear with no error pending returns bits 27:24 to 15 in the next cycle. A pulse that arrives in the clearing cycle sets bit 9 again and records its own code.
- R12: Write data bits other than 7 and 9 have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | 1 selects DMA transfer mode |
| rx_len_done | input | 1 | Receive of the programmed length is complete |
| rx_not_empty | input | 1 | RX FIFO holds data |
| rx_half_full | input | 1 | RX FIFO at least half full |
| tx_fifo_empty | input | 1 | TX FIFO empty |
| tx_not_full | input | 1 | TX FIFO has space |
| tx_half_empty | input | 1 | TX FIFO at least half empty |
| tx_shift_idle | input | 1 | TX shifter idle |
| tx_bytes_zero | input | 1 | DMA byte count is zero |
| brk_det | input | 1 | Break condition detected |
| cts_pin | input | 1 | Asynchronous clear-to-send line, low allows transmission |
| err_pulse | input | 5 | One-cycle error pulses, see R10 |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 32 | Write data, ones clear bits 7 and 9 |
| rd_data | output | 32 | Status word |

## Verification
Every live flag and every sticky update appears in `rd_data` one clock after the inputs that cause it. Bit 6 lags the pin by two clocks and the CTS-change flag by three. The bench drives inputs just after the falling edge. It advances a behavioural model at each rising edge, using the inputs sampled there and a queue of past CTS values. It compares every field at the next falling edge, so every cycle is checked at the point where its result is due. Directed sequences cover simultaneous errors, errors during a clear, and CTS edges that coincide with writes. Randomized cycles cover the remaining mode and flag combinations.

// File: rtl/uart_stat_reg.sv
module uart_stat_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dma_mode,
  input  logic        rx_len_done,
  input  logic        rx_not_empty,
  input  logic        rx_half_full,
  input  logic        tx_fifo_empty,
  input  logic        tx_not_full,
  input  logic        tx_half_empty,
  input  logic        tx_shift_idle,
  input  logic        tx_bytes_zero,
  input  logic        brk_det,
  input  logic        cts_pin,
  input  logic [4:0]  err_pulse,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);

  logic [5:0] live_q;
  logic       brk_q;
  logic       cts_s1, cts_s2, cts_s3;
  logic       tog_q;
  logic       err_q;
  logic [3:0] code_q;
  logic [3:0] code_nx;

  wire clr_err = wr_en & wr_data[9];
  wire clr_tog = wr_en & wr_data[7];
  wire cts_chg = cts_s2 ^ cts_s3;

  always_comb begin
    if      (err_pulse[0]) code_nx = 4'd0;
    else if (err_pulse[1]) code_nx = 4'd1;
    else if (err_pulse[2]) code_nx = 4'd12;
    else if (err_pulse[3]) code_nx = 4'd13;
    else                   code_nx = 4'd14;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 6'b110000;
      brk_q  <= 1'b0;
    end else begin
      live_q[0] <= dma_mode & rx_len_done;
      live_q[1] <= ~dma_mode & rx_not_empty;
      live_q[2] <= rx_half_full;
      live_q[3] <= tx_shift_idle & (dma_mode ? tx_bytes_zero : tx_fifo_empty);
      live_q[4] <= tx_not_full;
      live_q[5] <= tx_half_empty;
      brk_q     <= brk_det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1 <= 1'b1;
      cts_s2 <= 1'b1;
      cts_s3 <= 1'b1;
      tog_q  <= 1'b0;
    end else begin
      cts_s1 <= cts_pin;
      cts_s2 <= cts_s1;
      cts_s3 <= cts_s2;
      if (cts_chg)      tog_q <= 1'b1;
      else if (clr_tog) tog_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= 4'hF;
    end else if (err_q && !clr_err) begin
      err_q  <= 1'b1;
    end else if (|err_pulse) begin
      err_q  <= 1'b1;
      code_q <= code_nx;
    end else if (clr_err) begin
      err_q  <= 1'b0;
      code_q <= 4'hF;
    end
  end

  assign rd_data = {4'h0, code_q, 14'h0, err_q, brk_q, tog_q, ~cts_s2, live_q};

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> (err_q && $stable(code_q))); // R9
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> rd_data[9]); // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[9] |-> (rd_data[27:24] == 4'hF)); // R11
  AST_TOG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cts_chg |=> rd_data[7]); // R7
  AST_TXDONE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !tx_bytes_zero) |=> !rd_data[3]); // R4
  AST_RXDATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |=> !rd_data[1]); // R3
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:28] == 4'h0) && (rd_data[23:10] == 14'h0)); // R1

endmodule

// File: tb/uart_stat_reg_bench.sv
module uart_stat_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_mode = 0, rx_len_done = 0, rx_not_empty = 0, rx_half_full = 0;
  logic tx_fifo_empty = 1, tx_not_full = 1, tx_half_empty = 1, tx_shift_idle = 1;
  logic tx_bytes_zero = 1, brk_det = 0, cts_pin = 1, wr_en = 0;
  logic [4:0]  err_pulse = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;

  logic [31:0] exp_w = 32'h0F000030;
  bit m_tog = 0, m_err = 0;
  bit [3:0] m_code = 4'hF;
  bit cq[$];

  always #10 clk = ~clk;

  uart_stat_reg u_uart_stat_reg (
    .clk, .rst_n, .dma_mode, .rx_len_done, .rx_not_empty, .rx_half_full,
    .tx_fifo_empty, .tx_not_full, .tx_half_empty, .tx_shift_idle,
    .tx_bytes_zero, .brk_det, .cts_pin, .err_pulse, .wr_en, .wr_data, .rd_data);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1 R12 unused bits", {rd_data[31:28], rd_data[23:10]}, '0);
    chk("R2 rx done", rd_data[0], exp_w[0]);
    chk("R3 rx data/half", rd_data[2:1], exp_w[2:1]);
    chk("R4 tx done", rd_data[3], exp_w[3]);
    chk("R5 tx space/half", rd_data[5:4], exp_w[5:4]);
    chk("R6 cts status", rd_data[6], exp_w[6]);
    chk("R7 cts toggle", rd_data[7], exp_w[7]);
    chk("R8 break", rd_data[8], exp_w[8]);
    chk("R9 error flag", rd_data[9], exp_w[9]);
    chk("R10 R11 error code", rd_data[27:24], exp_w[27:24]);
  endtask

  function automatic bit [3:0] enc(logic [4:0] e);
    if (e[0]) return 0;
    if (e[1]) return 1;
    if (e[2]) return 12;
    if (e[3]) return 13;
    return 14;
  endfunction

  task automatic step();
    bit set_t;
    bit clr;
    @(posedge clk);
    set_t = (cq[1] != cq[2]);
    cq.push_front(cts_pin);
    void'(cq.pop_back());
    if (set_t) m_tog = 1;
    else if (wr_en && wr_data[7]) m_tog = 0;
    clr = wr_en && wr_data[9];
    if (m_err && !clr) m_err = 1;
    else if (|err_pulse) begin m_err = 1; m_code = enc(err_pulse); end
    else if (clr) begin m_err = 0; m_code = 4'hF; end
    exp_w = '0;
    exp_w[0] = dma_mode & rx_len_done;
    exp_w[1] = ~dma_mode & rx_not_empty;
    exp_w[2] = rx_half_full;
    exp_w[3] = tx_shift_idle & (dma_mode ? tx_bytes_zero : tx_fifo_empty);
    exp_w[4] = tx_not_full;
    exp_w[5] = tx_half_empty;
    exp_w[6] = ~cq[1];
    exp_w[7] = m_tog;
    exp_w[8] = brk_det;
    exp_w[9] = m_err;
    exp_w[27:24] = m_code;
    @(negedge clk);
    cmp_all();
    wr_en = 0; wr_data = 0; err_pulse = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cq = '{1'b1, 1'b1, 1'b1};
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, 32'h0F000030);
    rst_n = 1;
    @(negedge clk);
    step();
    // R9 R10: simultaneous pulses, lowest code wins, later errors held
    err_pulse = 5'b11100; step();
    chk("R10 lowest code", rd_data[27:24], 4'd12);
    err_pulse = 5'b00001; step();
    chk("R9 first code held", rd_data[27:24], 4'd12);
    // R11: error in clearing cycle re-records
    wr_en = 1; wr_data = 32'h200; err_pulse = 5'b10000; step();
    chk("R11 reload on clear", rd_data[27:24], 4'd14);
    wr_en = 1; wr_data = 32'h200; step();
    chk("R11 clear to 15", rd_data[27:24], 4'hF);
    // R12: writes to other bits ignored
    wr_en = 1; wr_data = 32'hFFFF_FD7F; err_pulse = 5'b00010; step();
    wr_en = 1; wr_data = 32'hFFFF_FD7F; step();
    chk("R12 no clear via other bits", rd_data[9], 1'b1);
    wr_en = 1; wr_data = 32'h200; step();
    // R6 R7: CTS edge timing, set wins over clear
    cts_pin = 0; step(); step();
    chk("R6 cts inverted", rd_data[6], 1'b1);
    wr_en = 1; wr_data = 32'h80; step();
    chk("R7 set wins", rd_data[7], 1'b1);
    wr_en = 1; wr_data = 32'h80; step();
    chk("R7 cleared", rd_data[7], 1'b0);
    // R4: DMA vs FIFO definition
    dma_mode = 1; tx_fifo_empty = 0; tx_bytes_zero = 1; tx_shift_idle = 1; step();
    chk("R4 dma done", rd_data[3], 1'b1);
    dma_mode = 0; step();
    chk("R4 fifo not done", rd_data[3], 1'b0);
    for (int i = 0; i < 4000; i++) begin
      {dma_mode, rx_len_done, rx_not_empty, rx_half_full, tx_fifo_empty,
       tx_not_full, tx_half_empty, tx_shift_idle, tx_bytes_zero, brk_det} = 10'($urandom);
      if ($urandom_range(0, 5) == 0) cts_pin = ~cts_pin;
      if ($urandom_range(0, 7) == 0) err_pulse = 5'($urandom);
      if ($urandom_range(0, 5) == 0) begin wr_en = 1; wr_data = $urandom; end
      step();
    end
    finish_run();
  end
endmodule